// File: doc/BRIEF.md
# Frame-Checked Configuration Stream Loader

This block sits on the path that brings a configuration image into a chip as a stream of 32-bit words. The image is cut into a fixed number of frames. Each frame holds a fixed number of data words and is followed by one word that carries the CRC of that frame. The loader works out the CRC of every frame as the words arrive. When the trailing word comes in, the loader compares it with its own result.

On the first frame whose check word disagrees, the loader raises a sticky failure flag and drops its ready. It then keeps showing the index of the frame that failed until a synchronous reset. If every frame passes, it raises a done flag and stores a 32-bit reference signature. That signature is the CRC of the whole image, taken over all data words of all frames in arrival order. A background integrity checker can compare against it later at run time.

Top module: `frame_crc_loader`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `in_ready` is 1, `load_done` is 0, `crc_fail` is 0, `frame_idx` is 0 and `ref_crc` is 0.
- R2: A word is taken only at a rising clock edge where `in_valid` and `in_ready` are both 1. Cycles with `in_valid` low do not change the progress or the result, whatever `in_data` holds.
- R3: The CRC of each frame follows these rules:
  - It uses generator 0x04C11DB7, with the register preset to 0xFFFFFFFF at the start of every frame.
  - Each word is fed most significant bit first, and no final inversion is applied.
  - A frame is `FRAME_WORDS` data words followed by one check word.
  - A check word that matches moves `frame_idx` up by one, except after the final frame.
- R4: A check word that does not match sets `crc_fail` from the next cycle onward, and it stays set until reset.
- R5: `in_ready` is 0 whenever `crc_fail` or `load_done` is 1.
- R6: After a failure, `frame_idx` shows the zero-based index of the frame that failed and holds it until reset.
- R7: `load_done` rises in the cycle after the check word of frame `NUM_FRAMES-1` is accepted and matches. It is never 1 together with `crc_fail`, and it stays 1 until reset.
- R8: `ref_crc` is 0 until `load_done` rises. It then holds the CRC, built under the rules of R3, of all data words of the image concatenated without a per-frame preset, and it does not change afterwards.
- R9: Words offered after a failure or after completion change none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream word present |
| in_data | input | 32 | Stream word, data or check word |
| in_ready | output | 1 | Loader can take a word |
| load_done | output | 1 | All frames passed |
| crc_fail | output | 1 | A frame failed its check (sticky) |
| frame_idx | output | max(1,clog2(NUM_FRAMES)) | Current or failing frame index |
| ref_crc | output | 32 | Whole-image reference CRC, valid with `load_done` |

## Verification
The hardest case to reach from the ports is a mismatch in the check word of the very last frame. There the failure and completion paths compete on the same edge, and done must stay low. To get there, the stimulus replays full images with a chosen frame and word corrupted: one bit of a data word in one run, one bit of the check word in another. The final frame is among the targets. Random stall gaps on `in_valid`, carrying junk data, run alongside so that progress is shown to depend only on real handshakes.

// File: rtl/frame_crc_loader.sv
`timescale 1ns/1ps
module frame_crc_loader #(
  parameter int          FRAME_WORDS = 4,
  parameter int          NUM_FRAMES  = 3,
  parameter logic [31:0] POLY        = 32'h04C11DB7,
  localparam int         IDXW        = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int         WCW         = $clog2(FRAME_WORDS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_data,
  output logic            in_ready,
  output logic            load_done,
  output logic            crc_fail,
  output logic [IDXW-1:0] frame_idx,
  output logic [31:0]     ref_crc
);
  localparam logic [31:0] SEED = 32'hFFFF_FFFF;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[i]) ? POLY : 32'h0);
    return r;
  endfunction

  logic [31:0]    frame_crc, image_crc;
  logic [WCW-1:0] wcnt;

  wire take    = in_valid & in_ready;
  wire at_chk  = (wcnt == WCW'(FRAME_WORDS));
  wire last_fr = (frame_idx == IDXW'(NUM_FRAMES - 1));

  assign in_ready = ~crc_fail & ~load_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_crc <= SEED;
      image_crc <= SEED;
      wcnt      <= '0;
      frame_idx <= '0;
      load_done <= 1'b0;
      crc_fail  <= 1'b0;
      ref_crc   <= '0;
    end else if (take) begin
      if (!at_chk) begin
        frame_crc <= crc_step(frame_crc, in_data);
        image_crc <= crc_step(image_crc, in_data);
        wcnt      <= wcnt + 1'b1;
      end else if (in_data != frame_crc) begin
        crc_fail <= 1'b1;
      end else begin
        frame_crc <= SEED;
        wcnt      <= '0;
        if (last_fr) begin
          load_done <= 1'b1;
          ref_crc   <= image_crc;
        end else begin
          frame_idx <= frame_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_crc_loader_chk.sv
`timescale 1ns/1ps
module frame_crc_loader_chk #(
  parameter int IDXW = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            load_done,
  input logic            crc_fail,
  input logic [IDXW-1:0] frame_idx,
  input logic [31:0]     ref_crc
);
  a_r2_idle_no_progress: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(frame_idx) && $stable(load_done) && $stable(crc_fail)));
  a_r4_fail_sticky: assert property (@(posedge clk) disable iff (rst)
    crc_fail |=> crc_fail);
  a_r4_fail_needs_take: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_fail) |-> $past(in_valid && in_ready));
  a_r5_ready_blocked: assert property (@(posedge clk) disable iff (rst)
    (crc_fail || load_done) |-> !in_ready);
  a_r6_idx_held: assert property (@(posedge clk) disable iff (rst)
    crc_fail |=> $stable(frame_idx));
  a_r7_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(load_done && crc_fail));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    load_done |=> load_done);
  a_r8_ref_zero_before: assert property (@(posedge clk) disable iff (rst)
    !load_done |-> (ref_crc == 32'h0));
  a_r8_ref_frozen: assert property (@(posedge clk) disable iff (rst)
    load_done |=> $stable(ref_crc));
endmodule

bind frame_crc_loader frame_crc_loader_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .load_done(load_done), .crc_fail(crc_fail), .frame_idx(frame_idx),
  .ref_crc(ref_crc)
);

// File: tb/sim_frame_crc_loader.sv
`timescale 1ns/1ps
module sim_frame_crc_loader;
  localparam int FW   = 4;
  localparam int NF   = 3;
  localparam int IDXW = (NF > 1) ? $clog2(NF) : 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, load_done, crc_fail;
  logic [IDXW-1:0] frame_idx;
  logic [31:0] ref_crc;
  int total = 0, fails = 0;
  bit use_bp = 1'b0;

  always #2.5 clk = ~clk;

  frame_crc_loader #(.FRAME_WORDS(FW), .NUM_FRAMES(NF)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .load_done(load_done), .crc_fail(crc_fail),
    .frame_idx(frame_idx), .ref_crc(ref_crc));

  function automatic logic [31:0] model_crc(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c ^ d;
    repeat (32) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    if (use_bp) begin
      int gap = $urandom_range(0, 3);
      repeat (gap) begin
        in_valid = 1'b0; in_data = $urandom;
        @(negedge clk);
      end
    end
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    in_valid = 1'b0; in_data = $urandom;
  endtask

  // kind: 0 clean, 1 corrupt data word, 2 corrupt check word
  task automatic run_load(input int bad_f, input int kind, input bit bp);
    logic [31:0] img [NF][FW];
    logic [31:0] c, g, w;
    int bad_w;
    use_bp = bp;
    do_reset();
    for (int f = 0; f < NF; f++)
      for (int k = 0; k < FW; k++) img[f][k] = $urandom;
    bad_w = $urandom_range(0, FW - 1);
    g = 32'hFFFF_FFFF;
    for (int f = 0; f < NF; f++) begin
      c = 32'hFFFF_FFFF;
      for (int k = 0; k < FW; k++) begin
        w = img[f][k];
        if (f == bad_f && kind == 1 && k == bad_w) w = w ^ (32'h1 << $urandom_range(0, 31));
        push(w);
        c = model_crc(c, img[f][k]);
        g = model_crc(g, img[f][k]);
      end
      chk("R7 done low before final check word", {31'b0, load_done}, 32'd0);
      w = c;
      if (f == bad_f && kind == 2) w = w ^ (32'h1 << $urandom_range(0, 31));
      push(w);
      if (f == bad_f && kind != 0) begin
        chk("R4 fail flag set", {31'b0, crc_fail}, 32'd1);
        chk("R6 failing frame index", 32'(frame_idx), 32'(f));
        chk("R5 ready low on fail", {31'b0, in_ready}, 32'd0);
        chk("R7 no done on fail", {31'b0, load_done}, 32'd0);
        chk("R8 ref zero without done", ref_crc, 32'd0);
        push(c);
        push($urandom);
        chk("R9 fail stays after extra words", {31'b0, crc_fail}, 32'd1);
        chk("R9 index unchanged after extra words", 32'(frame_idx), 32'(f));
        return;
      end
      chk("R3 frame passes", {31'b0, crc_fail}, 32'd0);
      if (f < NF - 1) chk("R3 index advances", 32'(frame_idx), 32'(f + 1));
    end
    chk("R7 done after last frame", {31'b0, load_done}, 32'd1);
    chk("R8 reference CRC", ref_crc, g);
    chk("R5 ready low on done", {31'b0, in_ready}, 32'd0);
    chk("R3 index holds last frame", 32'(frame_idx), 32'(NF - 1));
    if (bp) chk("R2 stalls leave result intact", ref_crc, g);
    push($urandom);
    push(32'hFFFF_FFFF);
    chk("R9 done stays after extra words", {31'b0, load_done}, 32'd1);
    chk("R9 ref unchanged after extra words", ref_crc, g);
    chk("R9 no fail after extra words", {31'b0, crc_fail}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    chk("R1 ready in reset", {31'b0, in_ready}, 32'd1);
    chk("R1 done in reset", {31'b0, load_done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 fail after reset", {31'b0, crc_fail}, 32'd0);
    chk("R1 index after reset", 32'(frame_idx), 32'd0);
    chk("R1 ref after reset", ref_crc, 32'd0);
    run_load(-1, 0, 1'b0);
    run_load(-1, 0, 1'b1);
    run_load(1, 1, 1'b1);
    run_load(0, 2, 1'b0);
    run_load(NF - 1, 2, 1'b1);
    run_load(NF - 1, 1, 1'b0);
    for (int i = 0; i < 8; i++)
      run_load($urandom_range(0, NF - 1), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule